// File: doc/BRIEF.md
# 65816 Bus Slave with Clock Generation

This block makes an FPGA act as both clock master and memory for an external 65816 processor. It divides the fabric clock to produce the processor's PHI2 clock. While PHI2 is low, it latches the 16-bit address from the address pins and the bank byte from the multiplexed data bus. It then completes the whole access before PHI2 falls again. Read data comes from a synchronous RAM port and is driven onto the data bus for the whole high phase of that same PHI2 cycle. Write data is taken from the bus just before PHI2 falls and committed to RAM at the 24-bit address.

A debug input makes every read return the single-byte no-op opcode. The processor then steps through incrementing addresses, and each captured address is reported on a strobe-qualified output so it can be recorded. The block also flags the bring-up sequence in which the processor fetches its reset vector, low byte then high byte. Reset holds the bus interface idle, but PHI2 keeps running so the processor sees a live clock while its own reset is applied.

Top module: `cpu_bus_slave`

## Requirements
- R1: PHI2 toggles every HALF_CLKS system clocks, so each phase lasts exactly HALF_CLKS clocks. It keeps toggling while `rst` is asserted.
- R2: On the system clock edge at which the low-phase counter equals CAPTURE_AT, the block captures `db_in` as the bank byte and `cpu_addr` as the address. After that edge, `cap_addr` holds {bank, address} (bank in bits 23:16) and `cap_stb` pulses for one clock.
- R3: For a read cycle (`cpu_rwb` = 1 at capture), a RAM read at {bank, address} is issued while PHI2 is still low. The byte returned by RAM appears on `db_out` from the first clock of the following high phase.
- R4: `db_oe` is 1 only during the high phase of a captured read cycle. It returns to 0 in the same clock that PHI2 falls and is 0 for write cycles.
- R5: For a write cycle (`cpu_rwb` = 0 at capture), `db_in` is sampled on the clock edge one clock before PHI2 falls. `ram_wr_en` then pulses for one clock, with `ram_wdata` equal to that byte and `ram_addr` equal to {bank, address}.
- R6: While `nop_mode` = 1, every read cycle drives 0xEA on `db_out`, whatever the RAM holds. Captured addresses are still reported on `cap_addr`.
- R7: `boot_seen` becomes 1 when two consecutive captured read cycles in bank 0 address 0xFFFC and then 0xFFFD. Once set, it stays 1 until reset.
- R8: While `rst` is asserted, `db_oe`, `ram_wr_en`, `ram_rd_en` and `cap_stb` stay 0, bus cycles are ignored, and `boot_seen` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset of the bus logic, active high |
| nop_mode | input | 1 | Debug: answer every read with 0xEA |
| phi2 | output | 1 | Processor clock |
| cpu_addr | input | 16 | Processor address pins |
| cpu_rwb | input | 1 | 1 = read, 0 = write |
| db_in | input | 8 | Data bus as seen from the pads |
| db_out | output | 8 | Data to drive onto the bus |
| db_oe | output | 1 | Data bus output enable |
| ram_addr | output | 24 | RAM address {bank, address} |
| ram_rd_en | output | 1 | RAM read request, data one clock later |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| cap_stb | output | 1 | One-clock pulse after each address capture |
| cap_addr | output | 24 | Last captured {bank, address} |
| boot_seen | output | 1 | Reset vector fetch sequence observed |

## Verification
The bench builds the block with HALF_CLKS = 8 and CAPTURE_AT = 2. Each PHI2 cycle then takes 16 clocks, so dozens of complete bus cycles run in a short test, and every phase boundary is crossed repeatedly. The bench's RAM model decodes only the low address byte, so its 256 locations are fully predictable. This lets read sweeps across many banks, write-then-read pairs, a run of incrementing no-op fetches and the ordering corners of the vector detector all be computed directly in the bench.

// File: rtl/cbs_pkg.sv
`timescale 1ns/1ps
package cbs_pkg;
  localparam int BANK_W = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int FULL_W = BANK_W + ADDR_W;

  localparam logic [DATA_W-1:0] NOP_OPCODE = 8'hEA;
  localparam logic [ADDR_W-1:0] VEC_LO     = 16'hFFFC;
  localparam logic [ADDR_W-1:0] VEC_HI     = 16'hFFFD;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] addr;
    logic              rd;
  } bus_req_t;

  // 24-bit memory address, bank in the upper byte
  function automatic logic [FULL_W-1:0] full_addr(bus_req_t r);
    return {r.bank, r.addr};
  endfunction

  // read of a given vector location in bank zero
  function automatic logic is_vec(bus_req_t r, logic [ADDR_W-1:0] v);
    return r.rd && (r.bank == '0) && (r.addr == v);
  endfunction
endpackage

// File: rtl/cbs_phi2_gen.sv
`timescale 1ns/1ps
module cbs_phi2_gen #(
  parameter int HALF_CLKS  = 128,
  parameter int CAPTURE_AT = 4
) (
  input  logic clk,
  output logic phi2,
  output logic cap_evt,
  output logic wsmp_evt
);
  localparam int CW = (HALF_CLKS > 2) ? $clog2(HALF_CLKS) : 2;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);
  localparam logic [CW-1:0] CAP  = CW'(CAPTURE_AT);
  localparam logic [CW-1:0] WSMP = CW'(HALF_CLKS - 2);

  // free-running divider: power-up value only, reset never stops PHI2
  logic [CW-1:0] cnt    = '0;
  logic          phi2_q = 1'b0;

  always_ff @(posedge clk) begin
    if (cnt == LAST) begin
      cnt    <= '0;
      phi2_q <= ~phi2_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign phi2     = phi2_q;
  assign cap_evt  = !phi2_q && (cnt == CAP);
  assign wsmp_evt =  phi2_q && (cnt == WSMP);
endmodule

// File: rtl/cbs_req_latch.sv
`timescale 1ns/1ps
module cbs_req_latch
  import cbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_evt,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rwb,
  input  logic [DATA_W-1:0] db_in,
  output bus_req_t          req,
  output logic              req_valid,
  output logic              cap_stb,
  output logic              ram_rd_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req       <= '0;
      req_valid <= 1'b0;
      cap_stb   <= 1'b0;
      ram_rd_en <= 1'b0;
    end else begin
      cap_stb   <= cap_evt;
      ram_rd_en <= cap_evt && cpu_rwb;
      if (cap_evt) begin
        req.bank  <= db_in;
        req.addr  <= cpu_addr;
        req.rd    <= cpu_rwb;
        req_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbs_data_path.sv
`timescale 1ns/1ps
module cbs_data_path
  import cbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic              wsmp_evt,
  input  logic              req_valid,
  input  logic              req_rd,
  input  logic              nop_mode,
  input  logic              ram_rd_en,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] db_in,
  output logic [DATA_W-1:0] db_out,
  output logic              db_oe,
  output logic              ram_wr_en,
  output logic [DATA_W-1:0] ram_wdata
);
  logic              rd_pend;
  logic [DATA_W-1:0] rd_hold;
  logic              wr_take;

  assign wr_take = wsmp_evt && req_valid && !req_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      rd_hold   <= '0;
      ram_wr_en <= 1'b0;
      ram_wdata <= '0;
    end else begin
      rd_pend   <= ram_rd_en;
      if (rd_pend) rd_hold <= ram_rdata;
      ram_wr_en <= wr_take;
      if (wr_take) ram_wdata <= db_in;
    end
  end

  assign db_oe  = phi2 && req_valid && req_rd && !rst;
  assign db_out = nop_mode ? NOP_OPCODE : rd_hold;
endmodule

// File: rtl/cbs_vec_detect.sv
`timescale 1ns/1ps
module cbs_vec_detect
  import cbs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cap_stb,
  input  bus_req_t req,
  output logic     boot_seen
);
  logic saw_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      saw_lo    <= 1'b0;
      boot_seen <= 1'b0;
    end else if (cap_stb) begin
      saw_lo <= is_vec(req, VEC_LO);
      if (saw_lo && is_vec(req, VEC_HI)) boot_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/cpu_bus_slave.sv
`timescale 1ns/1ps
module cpu_bus_slave
  import cbs_pkg::*;
#(
  parameter int HALF_CLKS  = 128,
  parameter int CAPTURE_AT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nop_mode,
  output logic              phi2,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rwb,
  input  logic [DATA_W-1:0] db_in,
  output logic [DATA_W-1:0] db_out,
  output logic              db_oe,
  output logic [FULL_W-1:0] ram_addr,
  output logic              ram_rd_en,
  output logic              ram_wr_en,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              cap_stb,
  output logic [FULL_W-1:0] cap_addr,
  output logic              boot_seen
);
  // named internal events
  logic     cap_evt;
  logic     wsmp_evt;
  bus_req_t req;
  logic     req_valid;

  cbs_phi2_gen #(.HALF_CLKS(HALF_CLKS), .CAPTURE_AT(CAPTURE_AT)) clkgen_i (
    .clk      (clk),
    .phi2     (phi2),
    .cap_evt  (cap_evt),
    .wsmp_evt (wsmp_evt)
  );

  cbs_req_latch latch_i (
    .clk       (clk),
    .rst       (rst),
    .cap_evt   (cap_evt),
    .cpu_addr  (cpu_addr),
    .cpu_rwb   (cpu_rwb),
    .db_in     (db_in),
    .req       (req),
    .req_valid (req_valid),
    .cap_stb   (cap_stb),
    .ram_rd_en (ram_rd_en)
  );

  cbs_data_path dpath_i (
    .clk       (clk),
    .rst       (rst),
    .phi2      (phi2),
    .wsmp_evt  (wsmp_evt),
    .req_valid (req_valid),
    .req_rd    (req.rd),
    .nop_mode  (nop_mode),
    .ram_rd_en (ram_rd_en),
    .ram_rdata (ram_rdata),
    .db_in     (db_in),
    .db_out    (db_out),
    .db_oe     (db_oe),
    .ram_wr_en (ram_wr_en),
    .ram_wdata (ram_wdata)
  );

  cbs_vec_detect vec_i (
    .clk       (clk),
    .rst       (rst),
    .cap_stb   (cap_stb),
    .req       (req),
    .boot_seen (boot_seen)
  );

  assign ram_addr = full_addr(req);
  assign cap_addr = full_addr(req);
endmodule

// File: rtl/cpu_bus_slave_chk.sv
`timescale 1ns/1ps
module cpu_bus_slave_chk #(
  parameter int HALF_CLKS = 128
) (
  input logic       clk,
  input logic       rst,
  input logic       nop_mode,
  input logic       phi2,
  input logic       db_oe,
  input logic [7:0] db_out,
  input logic       ram_rd_en,
  input logic       ram_wr_en,
  input logic       cap_stb,
  input logic       boot_seen
);
  logic [15:0] run       = '0;
  logic        prev_phi2 = 1'b0;
  logic        seen_edge = 1'b0;

  always_ff @(posedge clk) begin
    prev_phi2 <= phi2;
    if (phi2 != prev_phi2) begin
      run       <= '0;
      seen_edge <= 1'b1;
    end else begin
      run <= run + 1'b1;
    end
  end

  assert_half_period_R1: assert property (@(posedge clk)
    (seen_edge && (phi2 != prev_phi2)) |-> (run == 16'(HALF_CLKS - 1)));

  assert_rd_in_low_R3: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |-> !phi2);

  assert_oe_release_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(phi2) |-> !db_oe);

  assert_wr_in_high_R5: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en |-> (phi2 && !db_oe));

  assert_nop_drive_R6: assert property (@(posedge clk) disable iff (rst)
    (db_oe && nop_mode) |-> (db_out == 8'hEA));

  assert_boot_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    boot_seen |=> boot_seen);

  assert_reset_quiet_R8: assert property (@(posedge clk)
    (rst && $past(rst)) |-> (!ram_wr_en && !ram_rd_en && !db_oe && !cap_stb && !boot_seen));
endmodule

bind cpu_bus_slave cpu_bus_slave_chk #(.HALF_CLKS(HALF_CLKS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .nop_mode  (nop_mode),
  .phi2      (phi2),
  .db_oe     (db_oe),
  .db_out    (db_out),
  .ram_rd_en (ram_rd_en),
  .ram_wr_en (ram_wr_en),
  .cap_stb   (cap_stb),
  .boot_seen (boot_seen)
);

// File: tb/cpu_bus_slave_tb_top.sv
`timescale 1ns/1ps
module cpu_bus_slave_tb_top;
  localparam int HALF = 8;
  localparam int CAP  = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nop_mode = 1'b0;
  logic        phi2;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rwb = 1'b1;
  logic [7:0]  db_in = '0;
  logic [7:0]  db_out;
  logic        db_oe;
  logic [23:0] ram_addr;
  logic        ram_rd_en;
  logic        ram_wr_en;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic        cap_stb;
  logic [23:0] cap_addr;
  logic        boot_seen;

  always #2.5 clk = ~clk;

  cpu_bus_slave #(.HALF_CLKS(HALF), .CAPTURE_AT(CAP)) dut_i (
    .clk(clk), .rst(rst), .nop_mode(nop_mode), .phi2(phi2),
    .cpu_addr(cpu_addr), .cpu_rwb(cpu_rwb), .db_in(db_in),
    .db_out(db_out), .db_oe(db_oe), .ram_addr(ram_addr),
    .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .cap_stb(cap_stb), .cap_addr(cap_addr),
    .boot_seen(boot_seen)
  );

  // environment RAM: low address byte decoded, one clock read latency
  function automatic logic [7:0] seed(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  int          wr_count = 0;
  logic [23:0] last_wa = '0;
  logic [7:0]  last_wd = '0;
  int          tog = 0;

  initial for (int i = 0; i < 256; i++) begin
    mem[i] = seed(i);
    exp_mem[i] = seed(i);
  end

  always @(posedge clk) begin
    if (ram_rd_en) ram_rdata <= mem[ram_addr[7:0]];
    if (ram_wr_en) begin
      mem[ram_addr[7:0]] <= ram_wdata;
      wr_count <= wr_count + 1;
      last_wa  <= ram_addr;
      last_wd  <= ram_wdata;
    end
  end

  always @(phi2) tog++;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [7:0]  s_out;
  logic        s_oe;
  logic [23:0] s_cap;

  // one PHI2 cycle as driven by the processor; samples at first clock of high phase
  task automatic cyc(input logic [7:0] bank, input logic [15:0] a,
                     input logic rw, input logic [7:0] wd);
    @(negedge phi2);
    @(negedge clk);
    cpu_addr = a; db_in = bank; cpu_rwb = rw;
    @(posedge phi2);
    @(negedge clk);
    db_in = rw ? 8'h00 : wd;
    s_out = db_out; s_oe = db_oe; s_cap = cap_addr;
  endtask

  initial begin
    int w0;
    // R8 / R1: reset keeps the bus quiet while PHI2 runs
    repeat (3) @(negedge clk);
    chk("R8 oe at reset", 32'(db_oe), 32'd0);
    chk("R8 boot at reset", 32'(boot_seen), 32'd0);
    tog = 0;
    cyc(8'h00, 16'h0010, 1'b1, 8'h00);
    chk("R8 oe read under reset", 32'(s_oe), 32'd0);
    cyc(8'h00, 16'h0011, 1'b0, 8'h5A);
    cyc(8'h00, 16'h0012, 1'b1, 8'h00);
    chk("R8 no write under reset", 32'(wr_count), 32'd0);
    chk("R1 phi2 toggles under reset", 32'(tog >= 4), 32'd1);
    @(negedge clk); rst = 1'b0;

    // R2 / R3: read sweep across banks and addresses
    for (int i = 0; i < 16; i++) begin
      logic [7:0]  bk;
      logic [15:0] a;
      bk = 8'(i * 17);
      a  = 16'(16'h1200 + i * 16'h0103);
      cyc(bk, a, 1'b1, 8'h00);
      chk("R3 read data", 32'(s_out), 32'(exp_mem[a[7:0]]));
      chk("R4 oe on read", 32'(s_oe), 32'd1);
      chk("R2 captured address", 32'(s_cap), 32'({bk, a}));
    end
    // R4: released at the fall
    @(negedge phi2); @(negedge clk);
    chk("R4 oe after fall", 32'(db_oe), 32'd0);

    // R5: writes then read back
    for (int i = 0; i < 6; i++) begin
      logic [7:0]  bk;
      logic [15:0] a;
      logic [7:0]  wd;
      bk = 8'(8'h40 + i);
      a  = 16'(16'h3000 + i * 16'h0021);
      wd = 8'(8'hC3 ^ (i * 29));
      w0 = wr_count;
      cyc(bk, a, 1'b0, wd);
      chk("R4 oe on write", 32'(s_oe), 32'd0);
      exp_mem[a[7:0]] = wd;
      cyc(bk, a, 1'b1, 8'h00);
      chk("R5 one write strobe", 32'(wr_count - w0), 32'd1);
      chk("R5 write address", 32'(last_wa), 32'({bk, a}));
      chk("R5 write data", 32'(last_wd), 32'(wd));
      chk("R5 read back", 32'(s_out), 32'(wd));
    end

    // R6: debug no-op mode with incrementing fetches
    nop_mode = 1'b1;
    for (int i = 0; i < 10; i++) begin
      logic [15:0] a;
      a = 16'(16'h8000 + i);
      cyc(8'h00, a, 1'b1, 8'h00);
      chk("R6 no-op opcode", 32'(s_out), 32'h000000EA);
      chk("R6 fetch address", 32'(s_cap), 32'({8'h00, a}));
    end
    nop_mode = 1'b0;
    cyc(8'h00, 16'h8003, 1'b1, 8'h00);
    chk("R6 ram data after mode off", 32'(s_out), 32'(exp_mem[8'h03]));

    // R7: vector sequence ordering
    cyc(8'h00, 16'hFFFD, 1'b1, 8'h00);
    chk("R7 hi alone", 32'(boot_seen), 32'd0);
    cyc(8'h00, 16'hFFFC, 1'b1, 8'h00);
    chk("R7 lo alone", 32'(boot_seen), 32'd0);
    cyc(8'h01, 16'hFFFD, 1'b1, 8'h00);
    chk("R7 hi in wrong bank", 32'(boot_seen), 32'd0);
    cyc(8'h00, 16'hFFFC, 1'b0, 8'h11);
    exp_mem[8'hFC] = 8'h11;
    cyc(8'h00, 16'hFFFD, 1'b1, 8'h00);
    chk("R7 lo was a write", 32'(boot_seen), 32'd0);
    cyc(8'h00, 16'hFFFC, 1'b1, 8'h00);
    cyc(8'h00, 16'hFFFD, 1'b1, 8'h00);
    chk("R7 lo then hi", 32'(boot_seen), 32'd1);
    cyc(8'h02, 16'h0040, 1'b1, 8'h00);
    chk("R7 sticky", 32'(boot_seen), 32'd1);

    // R8: reset clears the flag
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 boot cleared", 32'(boot_seen), 32'd0);
    chk("R8 oe in reset", 32'(db_oe), 32'd0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end
endmodule